// File: doc/BRIEF.md
# Linked-List DMA Descriptor Fetcher

This block holds the parameters of one DMA channel and feeds them to a separate transfer engine. Software can program the first segment directly through a small field-write port. After that, the block follows a chain of descriptors stored in memory. Each descriptor is eight 32-bit words and sits on a 32-byte boundary. When the engine reports that the current segment's count has run out, the block checks the link of the segment just finished. If the link's chain flag is set, the block reads the next descriptor word by word over a simple read port. If the flag is clear, the channel stops and a transfer-complete pulse is raised.

Words fetched from memory first collect in a shadow bank. They become visible on the load interface all at once, in the cycle the configuration word (the last word) arrives. As a result, the engine never sees a mix of old and new fields. The link of the loaded segment stays readable at all times, so software can work out which descriptor is in flight.

Top module: `lli_fetch`

## Requirements
- R1: During and after reset, busy_o, ld_valid_o, tc_o and mem_req_o are 0, and cur_ptr_o is 0.
- R2: While idle, sw_wr_i writes the field selected by sw_sel_i (0 link, 1 count, 2 source, 3 destination, 4 configuration). A configuration write with bit 0 set makes ld_valid_o high for exactly one cycle, the cycle after the write, with the programmed fields on the ld_* outputs; busy_o rises in that same cycle.
- R3: A configuration write with bit 0 clear stores the fields but issues no load, and the channel stays idle.
- R4: Field writes are ignored while busy_o is high: cur_ptr_o and the ld_* outputs keep their values, and no extra load is issued.
- R5: When seg_done_i is seen while running and bit 1 of the current link is set, the block reads 8 words. They start at the link with its low 5 bits cleared and rise by 4 per word. Only one request is outstanding at a time, and mem_req_o and mem_addr_o hold steady until mem_rvalid_i.
- R6: Word 0 becomes the link, word 4 the count (only its low CNT_W bits kept, 13 by default), word 5 the source, word 6 the destination and word 7 the configuration. Words 1 to 3 are discarded. Source and destination have bits 1:0 forced to zero, both when fetched and when written by software.
- R7: A fetched descriptor is loaded, with one ld_valid_o pulse, only in the cycle after word 7 returns, never earlier.
- R8: When seg_done_i is seen while running and bit 1 of the link is clear (this includes a zero link), no read is issued. busy_o falls and tc_o pulses for one cycle. Segments that are followed by another in the chain raise no tc_o.
- R9: If a fetched descriptor has configuration bit 0 clear, its fields become current (visible on cur_ptr_o) but no load is issued. The channel goes idle without a tc_o pulse.
- R10: cur_ptr_o always shows the link field of the current descriptor, whether written by software or committed from memory.
- R11: seg_done_i is ignored while idle or while a fetch is under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_wr_i | input | 1 | Software field write strobe |
| sw_sel_i | input | 3 | Field select for the write |
| sw_wdata_i | input | AW | Write data |
| mem_req_o | output | 1 | Read request, held until answered |
| mem_addr_o | output | AW | Read word address (byte address) |
| mem_rvalid_i | input | 1 | Read data valid; answers the request |
| mem_rdata_i | input | AW | Read data |
| ld_valid_o | output | 1 | One-cycle load strobe to the transfer engine |
| ld_link_o | output | AW | Link of the loaded segment |
| ld_cnt_o | output | AW | Byte count of the loaded segment |
| ld_src_o | output | AW | Source address |
| ld_dst_o | output | AW | Destination address |
| ld_cfg_o | output | AW | Configuration word, bit 0 enable |
| seg_done_i | input | 1 | Engine reports segment count reached zero |
| cur_ptr_o | output | AW | Readback of the current link |
| busy_o | output | 1 | Channel running or fetching |
| tc_o | output | 1 | One-cycle pulse when the final segment ends |

## Verification
The checker assumes the memory side follows the protocol. mem_rvalid_i is raised only while mem_req_o is high, and only for one cycle per request, so the hold and address-step properties can count on each pulse answering exactly one word. The bench memory model follows these rules: it answers only an outstanding request, after a chosen latency, and drops the valid on the following cycle. seg_done_i is pulsed for one cycle at a time. It is also driven on purpose while the block is idle and while a fetch is under way, to show it has no effect there.

// File: rtl/lli_pkg.sv
`timescale 1ns/1ps
package lli_pkg;
  localparam int unsigned NUM_FLD        = 5;
  localparam int unsigned LINK_CHAIN_BIT = 1;
  localparam int unsigned CFG_EN_BIT     = 0;

  typedef enum logic [2:0] {
    FLD_LINK = 3'd0,
    FLD_CNT  = 3'd1,
    FLD_SRC  = 3'd2,
    FLD_DST  = 3'd3,
    FLD_CFG  = 3'd4
  } fld_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FETCH = 2'd2
  } st_e;

  // word offset of each field inside a descriptor
  function automatic int unsigned fld_word(input int unsigned f);
    case (f)
      0:       return 0;
      1:       return 4;
      2:       return 5;
      3:       return 6;
      default: return 7;
    endcase
  endfunction
endpackage

// File: rtl/lli_word_rd.sv
`timescale 1ns/1ps
module lli_word_rd #(
  parameter  int unsigned AW    = 32,
  parameter  int unsigned WORDS = 8,
  localparam int unsigned IDX_W = $clog2(WORDS),
  localparam int unsigned OFF_W = IDX_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [AW-1:0]    base_i,
  input  logic             mem_rvalid_i,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic             word_vld_o,
  output logic [IDX_W-1:0] word_idx_o,
  output logic             last_o
);
  logic                active_q;
  logic [IDX_W-1:0]    idx_q;
  logic [AW-OFF_W-1:0] blk_q;

  assign mem_req_o  = active_q;
  assign mem_addr_o = {blk_q, idx_q, 2'b00};
  assign word_vld_o = active_q && mem_rvalid_i;
  assign word_idx_o = idx_q;
  assign last_o     = word_vld_o && (idx_q == IDX_W'(WORDS-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      blk_q    <= '0;
    end else if (start_i && !active_q) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      blk_q    <= base_i[AW-1:OFF_W];
    end else if (word_vld_o) begin
      if (last_o) active_q <= 1'b0;
      idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/lli_desc_regs.sv
`timescale 1ns/1ps
module lli_desc_regs
  import lli_pkg::*;
#(
  parameter  int unsigned AW    = 32,
  parameter  int unsigned CNT_W = 13,
  parameter  int unsigned WORDS = 8,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sw_we_i,
  input  logic [2:0]                 sw_sel_i,
  input  logic [AW-1:0]              sw_wdata_i,
  input  logic                       word_vld_i,
  input  logic [IDX_W-1:0]           word_idx_i,
  input  logic [AW-1:0]              word_data_i,
  input  logic                       last_i,
  output logic [NUM_FLD-1:0][AW-1:0] fld_o
);
  localparam logic [AW-1:0] CNT_MASK = AW'((64'd1 << CNT_W) - 1);
  localparam logic [AW-1:0] ADR_MASK = ~AW'(3);

  for (genvar f = 0; f < NUM_FLD; f++) begin : g_fld
    localparam int unsigned WIDX = fld_word(f);
    localparam logic [AW-1:0] WMASK =
      (f == int'(FLD_CNT)) ? CNT_MASK :
      ((f == int'(FLD_SRC)) || (f == int'(FLD_DST))) ? ADR_MASK : '1;

    logic [AW-1:0] live_q, shad_q;
    logic          hit;

    assign hit = word_vld_i && (word_idx_i == IDX_W'(WIDX));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        live_q <= '0;
        shad_q <= '0;
      end else begin
        if (hit) shad_q <= word_data_i & WMASK;
        if (sw_we_i && (sw_sel_i == 3'(f))) live_q <= sw_wdata_i & WMASK;
        // whole descriptor becomes current together with its last word
        else if (last_i) live_q <= hit ? (word_data_i & WMASK) : shad_q;
      end
    end

    assign fld_o[f] = live_q;
  end
endmodule

// File: rtl/lli_fetch.sv
`timescale 1ns/1ps
module lli_fetch
  import lli_pkg::*;
#(
  parameter  int unsigned AW    = 32,
  parameter  int unsigned CNT_W = 13,
  parameter  int unsigned WORDS = 8,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sw_wr_i,
  input  logic [2:0]    sw_sel_i,
  input  logic [AW-1:0] sw_wdata_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_rvalid_i,
  input  logic [AW-1:0] mem_rdata_i,
  output logic          ld_valid_o,
  output logic [AW-1:0] ld_link_o,
  output logic [AW-1:0] ld_cnt_o,
  output logic [AW-1:0] ld_src_o,
  output logic [AW-1:0] ld_dst_o,
  output logic [AW-1:0] ld_cfg_o,
  input  logic          seg_done_i,
  output logic [AW-1:0] cur_ptr_o,
  output logic          busy_o,
  output logic          tc_o
);
  st_e                        st_q;
  logic                       ld_q, tc_q;
  logic [NUM_FLD-1:0][AW-1:0] fld;
  logic                       sw_we, chain, rd_start;
  logic                       word_vld, last;
  logic [IDX_W-1:0]           word_idx;

  assign chain    = fld[FLD_LINK][LINK_CHAIN_BIT];
  assign sw_we    = sw_wr_i && (st_q == ST_IDLE);
  assign rd_start = (st_q == ST_RUN) && seg_done_i && chain;

  lli_word_rd #(.AW(AW), .WORDS(WORDS)) u_rd (
    .clk_i, .rst_ni,
    .start_i      (rd_start),
    .base_i       (fld[FLD_LINK]),
    .mem_rvalid_i,
    .mem_req_o,
    .mem_addr_o,
    .word_vld_o   (word_vld),
    .word_idx_o   (word_idx),
    .last_o       (last)
  );

  lli_desc_regs #(.AW(AW), .CNT_W(CNT_W), .WORDS(WORDS)) u_regs (
    .clk_i, .rst_ni,
    .sw_we_i      (sw_we),
    .sw_sel_i,
    .sw_wdata_i,
    .word_vld_i   (word_vld),
    .word_idx_i   (word_idx),
    .word_data_i  (mem_rdata_i),
    .last_i       (last),
    .fld_o        (fld)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      ld_q <= 1'b0;
      tc_q <= 1'b0;
    end else begin
      ld_q <= 1'b0;
      tc_q <= 1'b0;
      case (st_q)
        ST_IDLE:
          if (sw_we && (sw_sel_i == FLD_CFG) && sw_wdata_i[CFG_EN_BIT]) begin
            st_q <= ST_RUN;
            ld_q <= 1'b1;
          end
        ST_RUN:
          if (seg_done_i) begin
            if (chain) st_q <= ST_FETCH;
            else begin
              st_q <= ST_IDLE;
              tc_q <= 1'b1;
            end
          end
        ST_FETCH:
          if (last) begin
            if (mem_rdata_i[CFG_EN_BIT]) begin
              st_q <= ST_RUN;
              ld_q <= 1'b1;
            end else st_q <= ST_IDLE;
          end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ld_valid_o = ld_q;
  assign ld_link_o  = fld[FLD_LINK];
  assign ld_cnt_o   = fld[FLD_CNT];
  assign ld_src_o   = fld[FLD_SRC];
  assign ld_dst_o   = fld[FLD_DST];
  assign ld_cfg_o   = fld[FLD_CFG];
  assign cur_ptr_o  = fld[FLD_LINK];
  assign busy_o     = (st_q != ST_IDLE);
  assign tc_o       = tc_q;
endmodule

// File: rtl/lli_fetch_chk.sv
`timescale 1ns/1ps
module lli_fetch_chk #(
  parameter  int unsigned AW       = 32,
  parameter  int unsigned WORDS    = 8,
  localparam int unsigned OFF_W    = $clog2(WORDS) + 2,
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'((WORDS-1)*4)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_rvalid_i,
  input logic          ld_valid_o,
  input logic          busy_o,
  input logic          tc_o
);
  AST_LD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_o |=> !ld_valid_o); // R2
  AST_LD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_o |-> busy_o); // R7
  AST_LD_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_valid_o && $past(mem_req_o)) |->
      $past(mem_rvalid_i && (mem_addr_o[OFF_W-1:0] == LAST_OFF))); // R7
  AST_TC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> (!busy_o && !ld_valid_o)); // R8
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o))); // R5
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_rvalid_i && (mem_addr_o[OFF_W-1:0] != LAST_OFF)) |=>
      (mem_req_o && (mem_addr_o == $past(mem_addr_o) + AW'(4)))); // R5
  AST_FIRST_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> (mem_addr_o[OFF_W-1:0] == '0)); // R5
  AST_NO_REQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o); // R11
endmodule

bind lli_fetch lli_fetch_chk #(.AW(AW), .WORDS(WORDS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_rvalid_i (mem_rvalid_i),
  .ld_valid_o   (ld_valid_o),
  .busy_o       (busy_o),
  .tc_o         (tc_o)
);

// File: tb/lli_fetch_tb_top.sv
`timescale 1ns/1ps
module lli_fetch_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sw_wr = 1'b0;
  logic [2:0]  sw_sel = '0;
  logic [31:0] sw_wdata = '0;
  logic        mem_req, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic        ld_valid, busy, tc;
  logic [31:0] ld_link, ld_cnt, ld_src, ld_dst, ld_cfg, cur_ptr;
  logic        seg_done = 1'b0;

  always #5 clk = ~clk;

  lli_fetch dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .sw_wr_i(sw_wr), .sw_sel_i(sw_sel), .sw_wdata_i(sw_wdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .ld_valid_o(ld_valid), .ld_link_o(ld_link), .ld_cnt_o(ld_cnt),
    .ld_src_o(ld_src), .ld_dst_o(ld_dst), .ld_cfg_o(ld_cfg),
    .seg_done_i(seg_done), .cur_ptr_o(cur_ptr),
    .busy_o(busy), .tc_o(tc)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  int lat = 0, wait_n = 0;
  int ld_n = 0, tc_n = 0, rd_n = 0;
  logic [31:0] mem [0:255];
  logic [31:0] rd_log [0:63];
  logic [31:0] lg_link [0:15], lg_cnt [0:15], lg_src [0:15], lg_dst [0:15], lg_cfg [0:15];
  int          lg_rd [0:15];

  // monitor and memory model, away from the active edge
  always @(negedge clk) begin
    if (ld_valid && ld_n < 16) begin
      lg_link[ld_n] = ld_link; lg_cnt[ld_n] = ld_cnt; lg_src[ld_n] = ld_src;
      lg_dst[ld_n] = ld_dst; lg_cfg[ld_n] = ld_cfg; lg_rd[ld_n] = rd_n;
    end
    if (ld_valid) ld_n++;
    if (tc) tc_n++;
    if (mem_rvalid) mem_rvalid = 1'b0;
    else if (mem_req) begin
      if (wait_n >= lat) begin
        mem_rvalid = 1'b1;
        mem_rdata  = mem[mem_addr[9:2]];
        if (rd_n < 64) rd_log[rd_n] = mem_addr;
        rd_n++;
        wait_n = 0;
      end else wait_n++;
    end else wait_n = 0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sw_write(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk); sw_wr = 1'b1; sw_sel = sel; sw_wdata = d;
    @(negedge clk); sw_wr = 1'b0; #1;
  endtask

  task automatic pulse_done();
    @(negedge clk); seg_done = 1'b1;
    @(negedge clk); seg_done = 1'b0; #1;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wait_ld(input int target);
    for (int i = 0; i < 300 && ld_n < target; i++) @(negedge clk);
    #1;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 300 && busy; i++) @(negedge clk);
    idle_cycles(2);
  endtask

  task automatic put_desc(input int a, input logic [31:0] lk, cn, s, d, c);
    mem[(a>>2)+0] = lk; mem[(a>>2)+4] = cn; mem[(a>>2)+5] = s;
    mem[(a>>2)+6] = d;  mem[(a>>2)+7] = c;
  endtask

  task automatic t_reset();
    chk("R1 busy", 32'(busy), 0);
    chk("R1 ld_valid", 32'(ld_valid), 0);
    chk("R1 tc", 32'(tc), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 cur_ptr", cur_ptr, 0);
  endtask

  task automatic t_stage_only();
    int b = ld_n;
    sw_write(3'd0, 32'h0000_0302);
    sw_write(3'd1, 32'h20);
    sw_write(3'd4, 32'h10);
    idle_cycles(3);
    chk("R3 no load", 32'(ld_n - b), 0);
    chk("R3 stays idle", 32'(busy), 0);
    chk("R10 ptr readback", cur_ptr, 32'h0000_0302);
  endtask

  task automatic t_single();
    int b = ld_n, bt = tc_n, br = rd_n;
    sw_write(3'd0, 32'h0);
    sw_write(3'd1, 32'hFFFF_1FFC);
    sw_write(3'd2, 32'h0000_4003);
    sw_write(3'd3, 32'h0000_8002);
    sw_write(3'd4, 32'h0000_0071);
    chk("R2 one load", 32'(ld_n - b), 1);
    chk("R2 busy", 32'(busy), 1);
    chk("R2 link", lg_link[b], 32'h0);
    chk("R6 count mask", lg_cnt[b], 32'h1FFC);
    chk("R6 src align", lg_src[b], 32'h4000);
    chk("R6 dst align", lg_dst[b], 32'h8000);
    chk("R2 cfg", lg_cfg[b], 32'h71);
    sw_write(3'd0, 32'hFFFF_FFE2);
    sw_write(3'd4, 32'h1);
    chk("R4 ptr unchanged", cur_ptr, 32'h0);
    chk("R4 no extra load", 32'(ld_n - b), 1);
    chk("R4 src unchanged", ld_src, 32'h4000);
    pulse_done();
    idle_cycles(2);
    chk("R8 tc once", 32'(tc_n - bt), 1);
    chk("R8 idle", 32'(busy), 0);
    chk("R8 no read", 32'(rd_n - br), 0);
  endtask

  task automatic t_chain();
    int b = ld_n, bt = tc_n, br = rd_n;
    lat = 2;
    put_desc(32'h100, 32'h0000_0122, 32'h10, 32'h0000_1101, 32'h0000_2203, 32'h0000_00F1);
    put_desc(32'h120, 32'h0, 32'hABC0_0008, 32'h0000_3000, 32'h0000_4000, 32'h3);
    sw_write(3'd0, 32'h0000_0102);
    sw_write(3'd1, 32'h40);
    sw_write(3'd2, 32'h1000);
    sw_write(3'd3, 32'h2000);
    sw_write(3'd4, 32'h1);
    chk("R2 first load", 32'(ld_n - b), 1);
    pulse_done();
    idle_cycles(3);
    pulse_done(); // lands during the fetch
    wait_ld(b + 2);
    chk("R11 one fetch only", 32'(rd_n - br), 8);
    for (int i = 0; i < 8; i++)
      chk("R5 ascending addr", rd_log[br + i], 32'h100 + 32'(4 * i));
    chk("R7 load after word 7", 32'(lg_rd[b + 1] - br), 8);
    chk("R6 link", lg_link[b + 1], 32'h122);
    chk("R6 count", lg_cnt[b + 1], 32'h10);
    chk("R6 src", lg_src[b + 1], 32'h1100);
    chk("R6 dst", lg_dst[b + 1], 32'h2200);
    chk("R6 cfg", lg_cfg[b + 1], 32'hF1);
    chk("R10 ptr after commit", cur_ptr, 32'h122);
    chk("R8 no tc mid chain", 32'(tc_n - bt), 0);
    pulse_done();
    wait_ld(b + 3);
    chk("R5 second fetch count", 32'(rd_n - br), 16);
    chk("R5 second base", rd_log[br + 8], 32'h120);
    chk("R5 second last", rd_log[br + 15], 32'h13C);
    chk("R6 count low bits", lg_cnt[b + 2], 32'h8);
    chk("R7 second load timing", 32'(lg_rd[b + 2] - lg_rd[b + 1]), 8);
    chk("R8 still no tc", 32'(tc_n - bt), 0);
    pulse_done();
    wait_idle();
    chk("R8 tc at end", 32'(tc_n - bt), 1);
    chk("R8 reads stop", 32'(rd_n - br), 16);
    chk("R10 zero link", cur_ptr, 32'h0);
    lat = 0;
  endtask

  task automatic t_idle_done();
    int b = ld_n, bt = tc_n, br = rd_n;
    pulse_done();
    idle_cycles(10);
    chk("R11 idle no read", 32'(rd_n - br), 0);
    chk("R11 idle no tc", 32'(tc_n - bt), 0);
    chk("R11 idle no load", 32'(ld_n - b), 0);
  endtask

  task automatic t_flag_clear();
    int bt = tc_n, br = rd_n;
    sw_write(3'd0, 32'h0000_0180);
    sw_write(3'd4, 32'h1);
    pulse_done();
    idle_cycles(5);
    chk("R8 flag clear no read", 32'(rd_n - br), 0);
    chk("R8 flag clear tc", 32'(tc_n - bt), 1);
  endtask

  task automatic t_cfg_off();
    int b = ld_n, bt = tc_n, br = rd_n;
    put_desc(32'h140, 32'h0000_0162, 32'h5, 32'h500, 32'h600, 32'h10);
    sw_write(3'd0, 32'h0000_0142);
    sw_write(3'd4, 32'h1);
    pulse_done();
    wait_idle();
    chk("R9 reads", 32'(rd_n - br), 8);
    chk("R9 no fetched load", 32'(ld_n - b), 1);
    chk("R9 no tc", 32'(tc_n - bt), 0);
    chk("R9 idle", 32'(busy), 0);
    chk("R9 fields current", cur_ptr, 32'h162);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 | 32'(i);
    idle_cycles(3);
    t_reset();
    rst_ni = 1'b1;
    idle_cycles(2);
    t_stage_only();
    t_single();
    t_chain();
    t_idle_done();
    t_flag_clear();
    t_cfg_off();
    idle_cycles(3);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule